// File: doc/BRIEF.md
# Load Effective Address Generator

This block turns a load instruction's addressing fields into the byte address the load will use. On a start strobe it takes a 3-bit mode code, a 16-bit offset field, the register number of the base register and the values of the base and index registers, which the surrounding pipeline has already read from its register file. It then returns a 32-bit effective address together with a one-cycle done pulse.

Most modes finish one cycle after start. The memory-indirect mode takes longer. The block issues one read on a plain request/response memory port, waits in a busy state for the answer, and uses the returned word as the address. The two auto-stepping modes also return a write-back request for the base register, which carries the register number and the stepped value. The caller uses that request to update its register file.

Top module: `lea_gen`

## Requirements
- R1: Mode code 0 (absolute) gives as address the 16-bit offset field sign-extended to 32 bits. The register values have no effect.
- R2: Mode code 1 (register indirect) gives the base register value as the address.
- R3: Mode code 2 (displaced) gives the base value plus the sign-extended offset. The sum wraps modulo 2^32.
- R4: Mode code 3 (indexed) gives the base value plus the index value. The sum wraps modulo 2^32.
- R5: Mode code 4 (memory indirect) raises `mem_req` for exactly one cycle, on the cycle after start, with `mem_addr` equal to the base value. `busy` stays high until `mem_rvalid` is seen. `done` then rises on the following cycle, with `ea` equal to `mem_rdata`.
- R6: Mode code 5 (auto-increment) gives the base value as the address. In the same cycle as `done` it pulses `wb_en` for one cycle, with `wb_num` equal to the base register number and `wb_val` equal to base+4, wrapping.
- R7: Mode code 6 (auto-decrement) gives base−4 as the address, wrapping. In the same cycle as `done` it pulses `wb_en` with `wb_val` equal to base−4.
- R8: Modes 0 to 3, 5 and 6 raise `done` for exactly one cycle, on the cycle after start. They raise no `mem_req`. Modes 0 to 4 never raise `wb_en`.
- R9: Mode code 7 is reserved. It raises `bad_mode` for one cycle, on the cycle after start, and raises no `done`, `wb_en` or `mem_req`.
- R10: A start that arrives while `busy` is high is ignored. The pending memory-indirect operation completes with its own result, and no extra `done` appears.
- R11: Synchronous reset leaves `done`, `wb_en`, `mem_req`, `bad_mode` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an address computation |
| mode | input | 3 | Addressing mode code |
| offset | input | 16 | Immediate / displacement field |
| base_num | input | 5 | Base register number |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| wb_en | output | 1 | Base register write-back pulse |
| wb_num | output | 5 | Write-back register number |
| wb_val | output | 32 | Write-back value |
| ea | output | 32 | Effective address |
| done | output | 1 | Address valid pulse |
| bad_mode | output | 1 | Reserved mode pulse |
| busy | output | 1 | Waiting for memory response |

## Verification
The bench builds the block with its default widths: 32-bit addresses, a 16-bit offset, 5-bit register numbers and a step of 4. With full-width addresses, base values near 0 and near 2^32−4 make the wrap of both the sum and the step directly observable. The behavioural memory answers two cycles after each request. This leaves idle waiting cycles in which a stray start can be injected, and it separates the request, the response and the done pulse into distinct cycles.

// File: rtl/lea_pkg.sv
package lea_pkg;
  typedef enum logic [2:0] {
    M_ABS  = 3'd0,
    M_RIND = 3'd1,
    M_DISP = 3'd2,
    M_IDX  = 3'd3,
    M_MIND = 3'd4,
    M_AINC = 3'd5,
    M_ADEC = 3'd6,
    M_RSVD = 3'd7
  } lea_mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } lea_state_e;
endpackage

// File: rtl/lea_calc.sv
module lea_calc import lea_pkg::*; #(
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int STEP = 4
) (
  input  logic [2:0]    mode,
  input  logic [OW-1:0] ofs,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] ea_c,
  output logic [AW-1:0] wbv_c,
  output logic          wb_want,
  output logic          needs_mem,
  output logic          illegal
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] f_sext(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] f_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] f_sub(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a - b;
  endfunction

  lea_mode_e m;
  assign m = lea_mode_e'(mode);

  always_comb begin
    ea_c      = base;
    wbv_c     = f_add(base, STEP_V);
    wb_want   = 1'b0;
    needs_mem = 1'b0;
    illegal   = 1'b0;
    case (m)
      M_ABS:  ea_c = f_sext(ofs);
      M_RIND: ea_c = base;
      M_DISP: ea_c = f_add(base, f_sext(ofs));
      M_IDX:  ea_c = f_add(base, idx);
      M_MIND: needs_mem = 1'b1;
      M_AINC: wb_want = 1'b1;
      M_ADEC: begin
        ea_c    = f_sub(base, STEP_V);
        wbv_c   = f_sub(base, STEP_V);
        wb_want = 1'b1;
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/lea_seq.sv
module lea_seq import lea_pkg::*; #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          needs_mem,
  input  logic          illegal,
  input  logic          wb_want,
  input  logic [AW-1:0] ea_c,
  input  logic [AW-1:0] wbv_c,
  input  logic [AW-1:0] base,
  input  logic [RW-1:0] base_num,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          wb_en,
  output logic [RW-1:0] wb_num,
  output logic [AW-1:0] wb_val,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          bad_mode,
  output logic          busy
);
  lea_state_e st;
  logic accept;

  assign busy   = (st == S_WAIT);
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      bad_mode <= 1'b0;
      mem_req  <= 1'b0;
      wb_en    <= 1'b0;
      mem_addr <= '0;
      wb_num   <= '0;
      wb_val   <= '0;
      ea       <= '0;
    end else begin
      done     <= 1'b0;
      bad_mode <= 1'b0;
      mem_req  <= 1'b0;
      wb_en    <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (illegal) begin
            bad_mode <= 1'b1;
          end else if (needs_mem) begin
            mem_req  <= 1'b1;
            mem_addr <= base;
            st       <= S_WAIT;
          end else begin
            done <= 1'b1;
            ea   <= ea_c;
            if (wb_want) begin
              wb_en  <= 1'b1;
              wb_num <= base_num;
              wb_val <= wbv_c;
            end
          end
        end
        default: if (mem_rvalid) begin
          done <= 1'b1;
          ea   <= mem_rdata;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  a_r11_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !done && !wb_en && !mem_req && !bad_mode && !busy);
  a_r8_done_next_cycle: assert property (@(posedge clk) disable iff (rst)
    accept && !needs_mem && !illegal |=> done && !mem_req && !bad_mode);
  a_r5_request_issued: assert property (@(posedge clk) disable iff (rst)
    accept && needs_mem |=> mem_req && busy && !done);
  a_r5_single_request: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r5_done_after_resp: assert property (@(posedge clk) disable iff (rst)
    busy && mem_rvalid |=> done && !busy);
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_rvalid |=> busy && !done && !wb_en);
  a_r9_bad_alone: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> !done && !wb_en && !mem_req);
  a_r6_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);
endmodule

// File: rtl/lea_gen.sv
module lea_gen import lea_pkg::*; #(
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int RW   = 5,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [OW-1:0] offset,
  input  logic [RW-1:0] base_num,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [RW-1:0] wb_num,
  output logic [AW-1:0] wb_val,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          bad_mode,
  output logic          busy
);
  logic [AW-1:0] ea_c, wbv_c;
  logic          wb_want, needs_mem, illegal;

  lea_calc #(.AW(AW), .OW(OW), .STEP(STEP)) u_calc (
    .mode(mode), .ofs(offset), .base(base_val), .idx(index_val),
    .ea_c(ea_c), .wbv_c(wbv_c), .wb_want(wb_want),
    .needs_mem(needs_mem), .illegal(illegal)
  );

  lea_seq #(.AW(AW), .RW(RW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .needs_mem(needs_mem), .illegal(illegal), .wb_want(wb_want),
    .ea_c(ea_c), .wbv_c(wbv_c), .base(base_val), .base_num(base_num),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .wb_en(wb_en), .wb_num(wb_num), .wb_val(wb_val),
    .ea(ea), .done(done), .bad_mode(bad_mode), .busy(busy)
  );

  a_r8_no_wb_plain_modes: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !wb_want |=> !wb_en);
  a_r6_wb_for_step_modes: assert property (@(posedge clk) disable iff (rst)
    start && !busy && wb_want |=> wb_en && done);
endmodule

// File: tb/sim_lea_gen.sv
`timescale 1ns/1ps
module sim_lea_gen;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] offset = '0;
  logic [4:0]  base_num = '0;
  logic [31:0] base_val = '0, index_val = '0;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        wb_en, done, bad_mode, busy;
  logic [4:0]  wb_num;
  logic [31:0] wb_val, ea;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lea_gen u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .offset(offset),
    .base_num(base_num), .base_val(base_val), .index_val(index_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_num(wb_num), .wb_val(wb_val),
    .ea(ea), .done(done), .bad_mode(bad_mode), .busy(busy)
  );

  // behavioural memory: 16 words, answers LAT cycles after the request
  logic [31:0] mem [16];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [3:0]  maddr = '0;
  assign mem_rvalid = pend && (cnt == 0);
  assign mem_rdata  = mem_rvalid ? mem[maddr] : 32'h0;

  always @(posedge clk) begin
    if (mem_req) begin
      pend  <= 1'b1;
      cnt   <= LAT;
      maddr <= mem_addr[5:2];
    end else if (pend) begin
      if (cnt == 0) pend <= 1'b0;
      else cnt <= cnt - 1;
    end
  end

  function automatic logic [31:0] word_at(input int i);
    return 32'hA000_0000 + 32'(i) * 32'h0000_0111;
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return 32'($signed(v));
  endfunction

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_reg(input string req, input logic [2:0] m, input logic [15:0] o,
                         input logic [4:0] bn, input logic [31:0] bv, input logic [31:0] iv,
                         input logic [31:0] exp_ea, input bit exp_wb, input logic [31:0] exp_wbv);
    @(negedge clk);
    mode = m; offset = o; base_num = bn; base_val = bv; index_val = iv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, done === 1'b1, 32'(done), 32'd1);
    check({req, " ea"}, ea === exp_ea, ea, exp_ea);
    check({req, " R8 no mem_req"}, mem_req === 1'b0, 32'(mem_req), 32'd0);
    check({req, " wb_en"}, wb_en === exp_wb, 32'(wb_en), 32'(exp_wb));
    if (exp_wb) begin
      check({req, " wb_val"}, wb_val === exp_wbv, wb_val, exp_wbv);
      check({req, " wb_num"}, wb_num === bn, 32'(wb_num), 32'(bn));
    end
    @(negedge clk);
    check({req, " R8 done single pulse"}, done === 1'b0 && wb_en === 1'b0, 32'(done), 32'd0);
  endtask

  task automatic t_reserved;
    @(negedge clk);
    mode = 3'd7; base_val = 32'h40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 bad_mode", bad_mode === 1'b1, 32'(bad_mode), 32'd1);
    check("R9 no done/wb/req", {done, wb_en, mem_req} === 3'b000, 32'({done, wb_en, mem_req}), 32'd0);
    @(negedge clk);
    check("R9 single pulse", bad_mode === 1'b0 && done === 1'b0, 32'(bad_mode), 32'd0);
  endtask

  task automatic t_mind(input int widx, input bit poke);
    bit prev_rv;
    bit got;
    logic [31:0] exp_ea;
    exp_ea = word_at(widx);
    @(negedge clk);
    mode = 3'd4; base_val = 32'(widx) * 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 request", mem_req === 1'b1 && busy === 1'b1, 32'(mem_req), 32'd1);
    check("R5 request address", mem_addr === 32'(widx) * 4, mem_addr, 32'(widx) * 4);
    check("R5 no early done", done === 1'b0, 32'(done), 32'd0);
    if (poke) begin
      mode = 3'd0; offset = 16'h0123; start = 1'b1;
    end
    prev_rv = mem_rvalid;
    got = 1'b0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && i == 0)
        check("R10 start ignored while busy", done === 1'b0 && busy === 1'b1, 32'(done), 32'd0);
      check("R5 request one cycle", mem_req === 1'b0, 32'(mem_req), 32'd0);
      if (done) begin
        got = 1'b1;
        check("R5 done one cycle after rvalid", prev_rv === 1'b1, 32'(prev_rv), 32'd1);
        check("R5 ea from memory", ea === exp_ea, ea, exp_ea);
        check("R5 busy released", busy === 1'b0 && wb_en === 1'b0, 32'(busy), 32'd0);
      end
      prev_rv = mem_rvalid;
    end
    check("R5 done arrived", got, 32'(got), 32'd1);
    @(negedge clk);
    check("R10 no extra done", done === 1'b0, 32'(done), 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = word_at(i);
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {done, wb_en, mem_req, bad_mode, busy} === 5'b0,
          32'({done, wb_en, mem_req, bad_mode, busy}), 32'd0);
    rst = 1'b0;

    run_reg("R1 absolute pos", 3'd0, 16'h1234, 5'd3, 32'hDEAD_BEEF, 32'h5, 32'h0000_1234, 1'b0, 32'h0);
    run_reg("R1 absolute neg", 3'd0, 16'h8000, 5'd3, 32'h0, 32'h0, sx(16'h8000), 1'b0, 32'h0);
    run_reg("R2 reg indirect", 3'd1, 16'h7777, 5'd4, 32'h1000_2000, 32'h9, 32'h1000_2000, 1'b0, 32'h0);
    run_reg("R3 displaced pos", 3'd2, 16'h0010, 5'd1, 32'h0000_1000, 32'h0, 32'h0000_1010, 1'b0, 32'h0);
    run_reg("R3 displaced neg", 3'd2, 16'hFFF0, 5'd1, 32'h0000_1000, 32'h0, 32'h0000_0FF0, 1'b0, 32'h0);
    run_reg("R3 displaced wrap", 3'd2, 16'h0008, 5'd1, 32'hFFFF_FFFC, 32'h0, 32'h0000_0004, 1'b0, 32'h0);
    run_reg("R4 indexed", 3'd3, 16'h0, 5'd2, 32'h0000_0100, 32'h0000_0024, 32'h0000_0124, 1'b0, 32'h0);
    run_reg("R4 indexed wrap", 3'd3, 16'h0, 5'd2, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_0010, 1'b0, 32'h0);
    run_reg("R6 auto-inc", 3'd5, 16'h0, 5'd7, 32'h0000_0200, 32'h0, 32'h0000_0200, 1'b1, 32'h0000_0204);
    run_reg("R6 auto-inc wrap", 3'd5, 16'h0, 5'd31, 32'hFFFF_FFFC, 32'h0, 32'hFFFF_FFFC, 1'b1, 32'h0);
    run_reg("R7 auto-dec", 3'd6, 16'h0, 5'd9, 32'h0000_0200, 32'h0, 32'h0000_01FC, 1'b1, 32'h0000_01FC);
    run_reg("R7 auto-dec wrap", 3'd6, 16'h0, 5'd0, 32'h0000_0000, 32'h0, 32'hFFFF_FFFC, 1'b1, 32'hFFFF_FFFC);
    t_reserved();
    t_mind(5, 1'b0);
    t_mind(11, 1'b1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 after mid-run reset", {done, wb_en, mem_req, bad_mode, busy} === 5'b0,
          32'({done, wb_en, mem_req, bad_mode, busy}), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule